// File: doc/BRIEF.md
# Matrix Converter Gate Sequencer

This block produces the switch gate pattern, one modulation period at a time, for a converter built from a six-switch current-source rectifier and a five-leg voltage inverter. The inverter feeds both ends of an open-end three-phase load. Its middle leg (leg C) is common to the far terminal of the first end and to one terminal of the second end. Every inverter state is a dual vector: one two-level vector drives legs A, B and C, and a second two-level vector drives the second end through legs C, D and E. No zero vector is ever applied, on either stage, so the period is filled with active states only.

Upstream control computes the sector numbers, the group choice and the duty counts in clock ticks. The block latches all of them at the start of each period. It then runs a counter over the period. For the first part of the period it holds the first rectifier vector and applies four inverter vectors in a fixed order. For the second part it switches to the second rectifier vector and applies the same four inverter vectors in reverse order. Each inverter duty is divided between the two parts in proportion to the two rectifier duties. The rectifier changes state only at the boundary between the two parts, which keeps the two stages in step.

Top module: `mcsv_gate_seq`

## Requirements
- R1: While reset is low, and until the first clock edge after reset is released, every gate output and both flags are 0.
- R2: A period lasts PERIOD clock ticks, numbered 0 to PERIOD-1. `frame_start` is 1 exactly on tick 0 of each period.
- R3: The rectifier vectors form the ring ab, ac, bc, ba, ca, cb (entries 1 to 6). Their `rect_g` codes, bits 5 to 0 = Sap, San, Sbp, Sbn, Scp, Scn, are ab=100100, ac=100001, bc=001001, ba=011000, ca=010010, cb=000110. In input sector s, the first vector is ring entry s and the second is entry s+1, wrapping from 6 to 1.
- R4: The first rectifier vector is held on ticks 0 to h-1 and the second on ticks h to PERIOD-1, where h = min(duty_r1, PERIOD). The rectifier never changes state at any other tick.
- R5: The two-level codes (first, second, third phase bit) are v0=000, v1=100, v2=110, v3=010, v4=011, v5=001, v6=101, v7=111. In a dual vector v_xy, `inv_g` bits 4, 3 and 2 (legs A, B, C) carry the first, second and third bits of x. With group 0, bit 1 (leg D) carries the second bit of y and bit 0 (leg E) carries the third bit of y. With group 1, leg D carries the third bit of y and leg E carries the first bit of y.
- R6: The group 0 ring is v13, v24, v35, v46, v51, v62. The group 1 ring is v64, v15, v26, v31, v42, v53. In output sector k, "near k" and "near k+1" are ring entries k and k+1, and the neighbours are entries k+2 and k-1, all taken modulo 6.
- R7: The first part applies neighbour k-1, then near k, then near k+1, then neighbour k+2. The first three last floor(duty_nbr*duty_r1/PERIOD), floor(duty_near1*duty_r1/PERIOD) and floor(duty_near2*duty_r1/PERIOD) ticks. Neighbour k+2 takes the rest of the first part.
- R8: The second part applies neighbour k+2, then near k+1, then near k, then neighbour k-1. The first three last floor(duty_nbr*duty_r2/PERIOD), floor(duty_near2*duty_r2/PERIOD) and floor(duty_near1*duty_r2/PERIOD) ticks. Neighbour k-1 runs to the end of the period.
- R9: Sectors, group and duties are sampled only at the start of a period. A change made in the middle of a period has no effect until the next period.
- R10: `duty_err` is 1 for a whole period whose latched counts give duty_r1+duty_r2 ≠ PERIOD or duty_near1+duty_near2+2*duty_nbr ≠ PERIOD. In that case segment ends are clamped: first-part ends to h, second-part ends to PERIOD. The last segment fills any remaining ticks, and segments that fall past the end of the period are cut.
- R11: `shared_err` is 1 when the applied x drives leg C to a level different from the terminal of y that leg C also serves (group 0: first bit of y; group 1: second bit of y). It stays 0 for every vector in the rings.
- R12: An input or output sector value of 0 or 7 is treated as sector 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of duty count |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sector | input | 3 | Input-current sector, 1..6 |
| out_sector | input | 3 | Output-voltage sector, 1..6 |
| group_sel | input | 1 | Dual-vector group: 0 or 1 |
| duty_r1 | input | DW | Ticks of the first rectifier vector |
| duty_r2 | input | DW | Ticks of the second rectifier vector |
| duty_near1 | input | DW | Period ticks of near vector k |
| duty_near2 | input | DW | Period ticks of near vector k+1 |
| duty_nbr | input | DW | Period ticks of each neighbour vector |
| rect_g | output | 6 | Rectifier gates Sap, San, Sbp, Sbn, Scp, Scn |
| inv_g | output | 5 | Inverter upper-switch gates, legs A..E |
| frame_start | output | 1 | High on tick 0 of each period |
| duty_err | output | 1 | Latched duty sums do not match the period |
| shared_err | output | 1 | Shared-leg level conflict in applied vector |

## Verification
The bench sweeps every combination of group, output sector and input sector with one consistent set of duties. This catches any mistake in the ring lookup, the wrap of ring entries, the rectifier codes or the assignment of legs D and E. Further periods push the rectifier split to its extremes (all ticks in the first part, all in the second) and give a single inverter vector the whole period. These show whether segment ends move as the proportional split requires and whether the rectifier edge follows h exactly. Periods with wrong duty sums show whether the status bit is set and the clamping is correct. Sector values 0 and 7, and inputs changed in the middle of a period, show the sector fallback and sampling only at period start.

// File: rtl/mcsv_pkg.sv
package mcsv_pkg;

    typedef logic [2:0] sec_t;

    // Out-of-range sector codes fall back to sector 1
    function automatic sec_t sec_fix(sec_t s);
        return (s == 3'd0 || s == 3'd7) ? 3'd1 : s;
    endfunction

    // Ring entry (s + off), entries numbered 1..6, off in 0..5
    function automatic sec_t ring_step(sec_t s, logic [2:0] off);
        logic [3:0] t;
        t = {1'b0, s} - 4'd1 + {1'b0, off};
        if (t >= 4'd6) t = t - 4'd6;
        return t[2:0] + 3'd1;
    endfunction

    // Rectifier current vector ring: ab ac bc ba ca cb
    function automatic logic [5:0] rect_code(sec_t idx);
        case (idx)
            3'd1:    return 6'b100100;
            3'd2:    return 6'b100001;
            3'd3:    return 6'b001001;
            3'd4:    return 6'b011000;
            3'd5:    return 6'b010010;
            default: return 6'b000110;
        endcase
    endfunction

    // Two-level vector phase bits, first phase in bit 2
    function automatic logic [2:0] tl_code(logic [2:0] v);
        case (v)
            3'd0:    return 3'b000;
            3'd1:    return 3'b100;
            3'd2:    return 3'b110;
            3'd3:    return 3'b010;
            3'd4:    return 3'b011;
            3'd5:    return 3'b001;
            3'd6:    return 3'b101;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/mcsv_seg_plan.sv
module mcsv_seg_plan #(
    parameter int PERIOD = 25000,
    parameter int DW     = $clog2(PERIOD + 1)
) (
    input  logic [DW-1:0] r1,
    input  logic [DW-1:0] r2,
    input  logic [DW-1:0] n1,
    input  logic [DW-1:0] n2,
    input  logic [DW-1:0] nb,
    output logic [DW-1:0] e1,
    output logic [DW-1:0] e2,
    output logic [DW-1:0] e3,
    output logic [DW-1:0] eh,
    output logic [DW-1:0] e5,
    output logic [DW-1:0] e6,
    output logic [DW-1:0] e7,
    output logic          err
);
    localparam int PW = 2 * DW + 2;
    typedef logic [PW-1:0] w_t;
    localparam w_t PER = w_t'(PERIOD);

    function automatic w_t share(logic [DW-1:0] a, logic [DW-1:0] b);
        return (w_t'(a) * w_t'(b)) / PER;
    endfunction

    function automatic w_t cap(w_t a, w_t lim);
        return (a > lim) ? lim : a;
    endfunction

    w_t c1, c2, c3, ch, c5, c6, c7;

    always_comb begin
        ch = cap(w_t'(r1), PER);
        c1 = cap(share(nb, r1), ch);
        c2 = cap(c1 + share(n1, r1), ch);
        c3 = cap(c2 + share(n2, r1), ch);
        c5 = cap(ch + share(nb, r2), PER);
        c6 = cap(c5 + share(n2, r2), PER);
        c7 = cap(c6 + share(n1, r2), PER);
        err = (w_t'(r1) + w_t'(r2) != PER) ||
              (w_t'(n1) + w_t'(n2) + (w_t'(nb) << 1) != PER);
    end

    assign e1 = DW'(c1);
    assign e2 = DW'(c2);
    assign e3 = DW'(c3);
    assign eh = DW'(ch);
    assign e5 = DW'(c5);
    assign e6 = DW'(c6);
    assign e7 = DW'(c7);

endmodule

// File: rtl/mcsv_gate_map.sv
module mcsv_gate_map
    import mcsv_pkg::*;
(
    input  logic       active,
    input  logic [2:0] seg,
    input  sec_t       isec,
    input  sec_t       osec,
    input  logic       grp,
    output logic [5:0] rect_g,
    output logic [4:0] inv_g,
    output logic       shared_err
);
    logic [2:0] off;
    sec_t       j, x, y;
    logic [2:0] xc, yc;
    logic       sh, leg_d, leg_e;

    always_comb begin
        // segment -> ring offset: first part k-1,k,k+1,k+2; second part mirrored
        case (seg)
            3'd0:    off = 3'd5;
            3'd1:    off = 3'd0;
            3'd2:    off = 3'd1;
            3'd3:    off = 3'd2;
            3'd4:    off = 3'd2;
            3'd5:    off = 3'd1;
            3'd6:    off = 3'd0;
            default: off = 3'd5;
        endcase
        j     = ring_step(osec, off);
        x     = ring_step(j, grp ? 3'd5 : 3'd0);
        y     = ring_step(j, grp ? 3'd3 : 3'd2);
        xc    = tl_code(x);
        yc    = tl_code(y);
        sh    = grp ? yc[1] : yc[2];
        leg_d = grp ? yc[0] : yc[1];
        leg_e = grp ? yc[2] : yc[0];
        rect_g     = active ? rect_code(ring_step(isec, {2'b00, seg[2]})) : 6'b0;
        inv_g      = active ? {xc[2], xc[1], xc[0], leg_d, leg_e} : 5'b0;
        shared_err = active && (xc[0] != sh);
    end

endmodule

// File: rtl/mcsv_gate_seq.sv
module mcsv_gate_seq
    import mcsv_pkg::*;
#(
    parameter  int PERIOD = 25000,
    localparam int DW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    in_sector,
    input  logic [2:0]    out_sector,
    input  logic          group_sel,
    input  logic [DW-1:0] duty_r1,
    input  logic [DW-1:0] duty_r2,
    input  logic [DW-1:0] duty_near1,
    input  logic [DW-1:0] duty_near2,
    input  logic [DW-1:0] duty_nbr,
    output logic [5:0]    rect_g,
    output logic [4:0]    inv_g,
    output logic          frame_start,
    output logic          duty_err,
    output logic          shared_err
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          run;
        sec_t          isec;
        sec_t          osec;
        logic          grp;
        logic [DW-1:0] b1;
        logic [DW-1:0] b2;
        logic [DW-1:0] b3;
        logic [DW-1:0] h;
        logic [DW-1:0] b5;
        logic [DW-1:0] b6;
        logic [DW-1:0] b7;
        logic          derr;
    } st_t;

    st_t st_d, st_q;

    logic [DW-1:0] p1, p2, p3, ph, p5, p6, p7;
    logic          perr;
    logic [2:0]    seg;

    mcsv_seg_plan #(.PERIOD(PERIOD), .DW(DW)) plan_i (
        .r1(duty_r1), .r2(duty_r2), .n1(duty_near1), .n2(duty_near2), .nb(duty_nbr),
        .e1(p1), .e2(p2), .e3(p3), .eh(ph), .e5(p5), .e6(p6), .e7(p7), .err(perr)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.run || st_q.cnt == DW'(PERIOD - 1)) begin
            st_d.cnt  = '0;
            st_d.run  = 1'b1;
            st_d.isec = sec_fix(in_sector);
            st_d.osec = sec_fix(out_sector);
            st_d.grp  = group_sel;
            st_d.b1   = p1;
            st_d.b2   = p2;
            st_d.b3   = p3;
            st_d.h    = ph;
            st_d.b5   = p5;
            st_d.b6   = p6;
            st_d.b7   = p7;
            st_d.derr = perr;
        end else begin
            st_d.cnt = st_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if      (st_q.cnt < st_q.b1) seg = 3'd0;
        else if (st_q.cnt < st_q.b2) seg = 3'd1;
        else if (st_q.cnt < st_q.b3) seg = 3'd2;
        else if (st_q.cnt < st_q.h)  seg = 3'd3;
        else if (st_q.cnt < st_q.b5) seg = 3'd4;
        else if (st_q.cnt < st_q.b6) seg = 3'd5;
        else if (st_q.cnt < st_q.b7) seg = 3'd6;
        else                         seg = 3'd7;
    end

    mcsv_gate_map map_i (
        .active(st_q.run), .seg(seg), .isec(st_q.isec), .osec(st_q.osec),
        .grp(st_q.grp), .rect_g(rect_g), .inv_g(inv_g), .shared_err(shared_err)
    );

    assign frame_start = st_q.run && (st_q.cnt == '0);
    assign duty_err    = st_q.run && st_q.derr;

    // internal views for the bound checker
    logic [DW-1:0] cnt_w, half_w;
    logic          run_w;
    assign cnt_w  = st_q.cnt;
    assign half_w = st_q.h;
    assign run_w  = st_q.run;

endmodule

// File: rtl/mcsv_gate_seq_chk.sv
module mcsv_gate_seq_chk #(
    parameter int PERIOD = 25000,
    parameter int DW     = $clog2(PERIOD + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [5:0]    rect_g,
    input logic [4:0]    inv_g,
    input logic          frame_start,
    input logic          shared_err,
    input logic [DW-1:0] cnt_w,
    input logic [DW-1:0] half_w,
    input logic          run_w
);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |-> (rect_g == 6'b0 && inv_g == 5'b0));

    assert_tick_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_w < DW'(PERIOD));

    assert_frame_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (run_w && cnt_w == '0));

    assert_rect_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_w |-> ($countones(rect_g) == 2 && $countones(rect_g & 6'b101010) == 1));

    assert_rect_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && $past(run_w) && !$stable(rect_g)) |-> (cnt_w == half_w || cnt_w == '0));

    assert_no_shared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !shared_err);
endmodule

bind mcsv_gate_seq mcsv_gate_seq_chk #(.PERIOD(PERIOD), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .rect_g(rect_g), .inv_g(inv_g),
    .frame_start(frame_start), .shared_err(shared_err),
    .cnt_w(cnt_w), .half_w(half_w), .run_w(run_w)
);

// File: tb/mcsv_gate_seq_tb.sv
`timescale 1ns/1ps
module mcsv_gate_seq_tb_top;
    localparam int P  = 40;
    localparam int DW = $clog2(P + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    in_sector = 3'd1, out_sector = 3'd1;
    logic          group_sel = 1'b0;
    logic [DW-1:0] duty_r1 = '0, duty_r2 = '0, duty_near1 = '0, duty_near2 = '0, duty_nbr = '0;
    logic [5:0]    rect_g;
    logic [4:0]    inv_g;
    logic          frame_start, duty_err, shared_err;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    string cur_tag = "R6";

    always #2 clk = ~clk;

    mcsv_gate_seq #(.PERIOD(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_sector(in_sector), .out_sector(out_sector),
        .group_sel(group_sel), .duty_r1(duty_r1), .duty_r2(duty_r2),
        .duty_near1(duty_near1), .duty_near2(duty_near2), .duty_nbr(duty_nbr),
        .rect_g(rect_g), .inv_g(inv_g), .frame_start(frame_start),
        .duty_err(duty_err), .shared_err(shared_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    function automatic int fsec(int s);
        return (s == 0 || s == 7) ? 1 : s;
    endfunction

    function automatic int wrap6(int s);
        return ((s - 1 + 12) % 6) + 1;
    endfunction

    function automatic int exp_rect(int idx);
        case (idx)
            1: return 'b100100;  // ab
            2: return 'b100001;  // ac
            3: return 'b001001;  // bc
            4: return 'b011000;  // ba
            5: return 'b010010;  // ca
            default: return 'b000110;  // cb
        endcase
    endfunction

    function automatic int tl(int v);
        case (v)
            0: return 'b000; 1: return 'b100; 2: return 'b110; 3: return 'b010;
            4: return 'b011; 5: return 'b001; 6: return 'b101; default: return 'b111;
        endcase
    endfunction

    function automatic int dual(int g, int j);
        int r0[6] = '{13, 24, 35, 46, 51, 62};
        int r1v[6] = '{64, 15, 26, 31, 42, 53};
        return g ? r1v[j-1] : r0[j-1];
    endfunction

    function automatic int mn(int a, int b);
        return (a < b) ? a : b;
    endfunction

    // one period; optional change of inputs in the middle (R9)
    task automatic run_period(input bit mid_change);
        int isec, osec, g, r1, r2, n1, n2, nb;
        int b1, b2, b3, h, b5, b6, b7;
        bit derr;
        isec = fsec(in_sector); osec = fsec(out_sector); g = group_sel;
        r1 = duty_r1; r2 = duty_r2; n1 = duty_near1; n2 = duty_near2; nb = duty_nbr;
        h  = mn(r1, P);
        b1 = mn(nb * r1 / P, h);
        b2 = mn(b1 + n1 * r1 / P, h);
        b3 = mn(b2 + n2 * r1 / P, h);
        b5 = mn(h + nb * r2 / P, P);
        b6 = mn(b5 + n2 * r2 / P, P);
        b7 = mn(b6 + n1 * r2 / P, P);
        derr = (r1 + r2 != P) || (n1 + n2 + 2 * nb != P);
        for (int t = 0; t < P; t++) begin
            int pos, ringoff, j, d, x, y, xc, yc, ei, er;
            @(negedge clk);
            if (t < b1) pos = 0; else if (t < b2) pos = 1; else if (t < b3) pos = 2;
            else if (t < h) pos = 3; else if (t < b5) pos = 4; else if (t < b6) pos = 5;
            else if (t < b7) pos = 6; else pos = 7;
            case (pos)
                0, 7: ringoff = -1;
                1, 6: ringoff = 0;
                2, 5: ringoff = 1;
                default: ringoff = 2;
            endcase
            j  = wrap6(osec + ringoff);
            d  = dual(g, j);
            x  = d / 10; y = d % 10;
            xc = tl(x); yc = tl(y);
            if (g == 0) ei = (xc << 2) | (((yc >> 1) & 1) << 1) | (yc & 1);
            else        ei = (xc << 2) | ((yc & 1) << 1) | ((yc >> 2) & 1);
            er = exp_rect(wrap6(isec + ((t < h) ? 0 : 1)));
            chk(rect_g == 6'(er), $sformatf("R3 R4 rectifier t=%0d %s", t, cur_tag), rect_g, er);
            chk(inv_g == 5'(ei), $sformatf("R5 R7 R8 inverter t=%0d %s", t, cur_tag), inv_g, ei);
            chk(frame_start == (t == 0), $sformatf("R2 frame t=%0d", t), frame_start, t == 0);
            chk(duty_err == derr, $sformatf("R10 duty_err t=%0d", t), duty_err, derr);
            chk(shared_err == 1'b0, "R11 shared_err", shared_err, 0);
            if (mid_change && t == P / 2) begin
                in_sector  = 3'(wrap6(isec + 3));
                out_sector = 3'(wrap6(osec + 2));
                group_sel  = ~group_sel;
                duty_r1    = DW'(5);
                duty_r2    = DW'(35);
            end
        end
    endtask

    task automatic set_duty(input int r1, input int r2, input int n1, input int n2, input int nb);
        duty_r1 = DW'(r1); duty_r2 = DW'(r2);
        duty_near1 = DW'(n1); duty_near2 = DW'(n2); duty_nbr = DW'(nb);
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL R2 watchdog expired");
            finish_run();
        end
    end

    initial begin
        set_duty(16, 24, 12, 10, 9);
        // R1: outputs idle during reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(rect_g == 6'b0 && inv_g == 5'b0, "R1 gates in reset", {rect_g, inv_g}, 0);
            chk(!frame_start && !duty_err && !shared_err, "R1 flags in reset",
                {frame_start, duty_err, shared_err}, 0);
        end
        rst_n = 1'b1;
        chk(rect_g == 6'b0 && inv_g == 5'b0, "R1 gates before first edge", {rect_g, inv_g}, 0);

        // R6 sweep of group, output sector and input sector
        cur_tag = "R6 sweep";
        for (int g = 0; g < 2; g++)
            for (int o = 1; o <= 6; o++)
                for (int s = 1; s <= 6; s++) begin
                    group_sel = 1'(g); out_sector = 3'(o); in_sector = 3'(s);
                    run_period(1'b0);
                end

        // R7 R8: extreme splits
        cur_tag = "R7 R8 split";
        group_sel = 1'b0; out_sector = 3'd2; in_sector = 3'd3;
        set_duty(0, 40, 12, 10, 9);  run_period(1'b0);
        set_duty(40, 0, 12, 10, 9);  run_period(1'b0);
        set_duty(20, 20, 40, 0, 0);  run_period(1'b0);
        group_sel = 1'b1; out_sector = 3'd6; in_sector = 3'd6;
        set_duty(20, 20, 0, 0, 20);  run_period(1'b0);
        set_duty(33, 7, 3, 27, 5);   run_period(1'b0);

        // R10: inconsistent duty sums
        cur_tag = "R10 clamp";
        set_duty(30, 30, 12, 10, 9); run_period(1'b0);
        set_duty(10, 10, 12, 10, 9); run_period(1'b0);
        set_duty(20, 20, 30, 30, 10); run_period(1'b0);
        set_duty(50, 5, 12, 10, 9);  run_period(1'b0);

        // R12: out-of-range sectors
        cur_tag = "R12 sector fallback";
        set_duty(16, 24, 12, 10, 9);
        group_sel = 1'b0; in_sector = 3'd0; out_sector = 3'd7; run_period(1'b0);
        group_sel = 1'b1; in_sector = 3'd7; out_sector = 3'd0; run_period(1'b0);

        // R9: mid-period change takes effect only next period
        cur_tag = "R9 latch";
        group_sel = 1'b0; in_sector = 3'd4; out_sector = 3'd5;
        run_period(1'b1);
        run_period(1'b0);

        finish_run();
    end
endmodule